// File: doc/BRIEF.md
# Calendar Registers With Write-Busy Flags

This block is the time-of-day and calendar keeper of a real-time clock. It holds seconds, minutes, hours, day of month, month, a 6-bit year counted from 1970 and a stored leap-year bit. All of these advance by one second on every pulse of a one-second tick input. Software sees the state as two packed 32-bit words on a simple register bus: a clock word and a calendar word. A third word reports a busy flag for each of the two.

A bus write does not change the running counters at once. It is held in a staging register. It takes effect only on the `COMMIT_TICKS`-th tick after the write, which models the hand-over into a slow clock domain. While a commit is pending, the matching busy bit reads 1. Reads keep returning the live counters, which go on running from their old values. Software polls the busy bit before it trusts a read-back or starts another write.

The bus is a plain register interface: a one-cycle write strobe with address and data, and a read port whose data follows the address combinationally. There is no back-pressure. A write is always accepted in the cycle of its strobe.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset the clock word (address 0x14) reads 0x00000000, the calendar word (address 0x10) reads 0x00000101 (day 1, month 1, year 0, leap bit 0), and the status word (address 0x00) reads 0.
- R2: Each cycle with `tick_i` high advances the seconds by one. With no tick and no commit, both words keep their value.
- R3: Clock word layout: seconds in bits [5:0], minutes in [13:8], hours in [20:16]. A seconds value at or above 59 wraps to 0 and carries into the minutes. Minutes at or above 59 wrap to 0 and carry into the hours. Hours at or above 23 wrap to 0 and advance the day.
- R4: Calendar word layout: day in bits [4:0], month (1 to 12) in [11:8], year offset in [21:16], leap bit in [22]. A day at or above the month length wraps to 1 and advances the month. Months 4, 6, 9 and 11 have 30 days, month 2 has 29 days when the leap bit is 1 and 28 when it is 0, and all other months have 31.
- R5: A month at or above 12 wraps to 1 and advances the year. Year 63 wraps to 0. On every year advance, the leap bit becomes 1 exactly when the new year's two low bits are 2 (1970 + year divisible by four).
- R6: A write to address 0x14 sets status bit 8 from the next cycle on. The bit stays 1 through the following `COMMIT_TICKS`-1 ticks and clears at the edge of the `COMMIT_TICKS`-th tick.
- R7: A write to address 0x10 sets status bit 7 in the same way, with the same tick count.
- R8: While a commit is pending, reads of that word return the old counter value, which keeps advancing with the ticks.
- R9: A second write to a word while its commit is pending replaces the staged value and restarts the count from `COMMIT_TICKS`.
- R10: At the commit tick the word takes the staged value exactly. The value is not advanced by that tick, and a carry into the calendar at that tick is overridden by a calendar commit.
- R11: Only the field bits of a written word are stored, so writing all ones reads back 0x001F3F3F (clock) and 0x007F0F1F (calendar). All other status bits and every unmapped address read 0.
- R12: Writes to the status address or to any unmapped address change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Read data follows the address in the same cycle. Everything else moves only at a clock edge. A write's busy bit is therefore visible on the cycle after the strobe. A tick's effect appears after the edge that saw the tick. A committed value appears after the edge of the `COMMIT_TICKS`-th tick following the write. The bench drives each stimulus on a falling edge and holds it for one full cycle. It then sets the address on a later falling edge and samples shortly after, so each read sees every edge the stimulus needed and no more. The busy-flag and pending-read checks are placed after each single tick, which pins down both the tick count and the old value the counters hold meanwhile.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  typedef struct packed {
    logic       leap;
    logic [5:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
  } ymd_t;

  localparam logic [5:0] SEC_LAST = 6'd59;
  localparam logic [5:0] MIN_LAST = 6'd59;
  localparam logic [4:0] HR_LAST  = 5'd23;
  localparam logic [3:0] MON_LAST = 4'd12;

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
    logic [4:0] n;
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
      4'd2:                    n = leap ? 5'd29 : 5'd28;
      default:                 n = 5'd31;
    endcase
    return n;
  endfunction

  // 1970 + yr divisible by four <=> yr mod 4 == 2 (range 1970..2033)
  function automatic logic leap_of(input logic [5:0] yr);
    return yr[1:0] == 2'd2;
  endfunction

  function automatic logic [WORD_W-1:0] hms_word(input hms_t h);
    return {11'd0, h.hr, 2'd0, h.mn, 2'd0, h.sc};
  endfunction

  function automatic logic [WORD_W-1:0] ymd_word(input ymd_t d);
    return {9'd0, d.leap, d.yr, 4'd0, d.mon, 3'd0, d.day};
  endfunction
endpackage

// File: rtl/rtc_commit_delay.sv
`timescale 1ns/1ps
module rtc_commit_delay #(
  parameter int unsigned TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic tick_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (wr_i)                     cnt_q <= CW'(TICKS);
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = tick_i && !wr_i && (cnt_q == CW'(1));

  p_wr_sets_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> busy_o);
  p_busy_falls_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i));
  p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !busy_o);
endmodule

// File: rtl/rtc_hms_counter.sv
`timescale 1ns/1ps
module rtc_hms_counter
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic load_i,
  input  hms_t load_val_i,
  output hms_t hms_o,
  output logic day_carry_o
);
  hms_t hms_q, hms_nxt;
  logic wrap_day;

  always_comb begin
    hms_nxt  = hms_q;
    wrap_day = 1'b0;
    if (hms_q.sc >= SEC_LAST) begin
      hms_nxt.sc = '0;
      if (hms_q.mn >= MIN_LAST) begin
        hms_nxt.mn = '0;
        if (hms_q.hr >= HR_LAST) begin
          hms_nxt.hr = '0;
          wrap_day   = 1'b1;
        end else begin
          hms_nxt.hr = hms_q.hr + 5'd1;
        end
      end else begin
        hms_nxt.mn = hms_q.mn + 6'd1;
      end
    end else begin
      hms_nxt.sc = hms_q.sc + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hms_q <= '0;
    else if (load_i) hms_q <= load_val_i;
    else if (tick_i) hms_q <= hms_nxt;
  end

  assign hms_o       = hms_q;
  assign day_carry_o = tick_i && !load_i && wrap_day;

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && hms_q.sc < SEC_LAST) |=> hms_q.sc == $past(hms_q.sc) + 6'd1);
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(hms_q));
  p_load_exact_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> hms_q == $past(load_val_i));
  p_carry_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry_o |=> hms_q == '0);
endmodule

// File: rtl/rtc_ymd_counter.sv
`timescale 1ns/1ps
module rtc_ymd_counter
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic load_i,
  input  ymd_t load_val_i,
  output ymd_t ymd_o
);
  ymd_t ymd_q, ymd_nxt;
  logic [5:0] yr_inc;

  assign yr_inc = ymd_q.yr + 6'd1;

  always_comb begin
    ymd_nxt = ymd_q;
    if (ymd_q.day >= month_len(ymd_q.mon, ymd_q.leap)) begin
      ymd_nxt.day = 5'd1;
      if (ymd_q.mon >= MON_LAST) begin
        ymd_nxt.mon  = 4'd1;
        ymd_nxt.yr   = yr_inc;
        ymd_nxt.leap = leap_of(yr_inc);
      end else begin
        ymd_nxt.mon = ymd_q.mon + 4'd1;
      end
    end else begin
      ymd_nxt.day = ymd_q.day + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ymd_q <= '{leap: 1'b0, yr: 6'd0, mon: 4'd1, day: 5'd1};
    end else if (load_i) begin
      ymd_q <= load_val_i;
    end else if (inc_i) begin
      ymd_q <= ymd_nxt;
    end
  end

  assign ymd_o = ymd_q;

  p_date_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(ymd_q));
  p_year_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && ymd_q.yr == 6'd63 && ymd_q.mon >= MON_LAST &&
     ymd_q.day >= 5'd31) |=> (ymd_q.yr == 6'd0 && ymd_q.mon == 4'd1 && ymd_q.day == 5'd1));
  p_date_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ymd_q == $past(load_val_i));
endmodule

// File: rtl/rtc_calendar_regs.sv
`timescale 1ns/1ps
module rtc_calendar_regs
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned COMMIT_TICKS = 3,
  parameter int unsigned OFS_STATUS   = 'h00,
  parameter int unsigned OFS_DATE     = 'h10,
  parameter int unsigned OFS_TIME     = 'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned NUM_CH   = 2;
  localparam int unsigned CH_TIME  = 0;
  localparam int unsigned CH_DATE  = 1;
  localparam int unsigned BIT_TIME = 8;
  localparam int unsigned BIT_DATE = 7;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_DATE   = ADDR_W'(OFS_DATE);
  localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(OFS_TIME);

  logic [NUM_CH-1:0] ch_wr, ch_busy, ch_commit;
  hms_t time_stg, cur_time;
  ymd_t date_stg, cur_date;
  logic day_carry;
  logic unused_wdata_par;

  assign ch_wr[CH_TIME] = bus_wr && (bus_addr == A_TIME);
  assign ch_wr[CH_DATE] = bus_wr && (bus_addr == A_DATE);
  assign unused_wdata_par = ^bus_wdata;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      rtc_commit_delay #(.TICKS(COMMIT_TICKS)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ch_wr[g]),
        .tick_i   (tick_i),
        .busy_o   (ch_busy[g]),
        .commit_o (ch_commit[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_stg <= '0;
      date_stg <= '0;
    end else begin
      if (ch_wr[CH_TIME])
        time_stg <= '{hr: bus_wdata[20:16], mn: bus_wdata[13:8], sc: bus_wdata[5:0]};
      if (ch_wr[CH_DATE])
        date_stg <= '{leap: bus_wdata[22], yr: bus_wdata[21:16],
                      mon: bus_wdata[11:8], day: bus_wdata[4:0]};
    end
  end

  rtc_hms_counter u_hms (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .load_i      (ch_commit[CH_TIME]),
    .load_val_i  (time_stg),
    .hms_o       (cur_time),
    .day_carry_o (day_carry)
  );

  rtc_ymd_counter u_ymd (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (day_carry),
    .load_i     (ch_commit[CH_DATE]),
    .load_val_i (date_stg),
    .ymd_o      (cur_date)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STATUS) begin
      bus_rdata[BIT_TIME] = ch_busy[CH_TIME];
      bus_rdata[BIT_DATE] = ch_busy[CH_DATE];
    end else if (bus_addr == A_DATE) begin
      bus_rdata = ymd_word(cur_date);
    end else if (bus_addr == A_TIME) begin
      bus_rdata = hms_word(cur_time);
    end
  end

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_busy[CH_TIME] && !tick_i) |=> ch_busy[CH_TIME]);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_busy[CH_DATE] && !tick_i) |=> ch_busy[CH_DATE]);
  p_old_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_busy[CH_TIME] && !tick_i) |=> $stable(cur_time));
endmodule

// File: tb/sim_rtc_calendar_regs.sv
`timescale 1ns/1ps
module sim_rtc_calendar_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ST = 8'h00, A_DT = 8'h10, A_TM = 8'h14, A_NONE = 8'h18;
  localparam logic [31:0] BUSY_T = 32'h100, BUSY_D = 32'h080;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_regs u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] tw(int h, int m, int s);
    return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction
  function automatic logic [31:0] dw(int lp, int y, int mo, int d);
    return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick_once();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic set_time(logic [31:0] w);
    bus_write(A_TM, w);
    repeat (3) tick_once();
  endtask

  task automatic set_date(logic [31:0] w);
    bus_write(A_DT, w);
    repeat (3) tick_once();
  endtask

  task automatic expect_reg(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 time after reset", A_TM, 32'h0);
    expect_reg("R1 date after reset", A_DT, 32'h00000101);
    expect_reg("R1 status after reset", A_ST, 32'h0);
  endtask

  task automatic t_hold_and_step();
    repeat (5) @(negedge clk);
    expect_reg("R2 no tick hold", A_TM, 32'h0);
    tick_once();
    expect_reg("R2 one tick step", A_TM, tw(0, 0, 1));
  endtask

  task automatic t_time_commit();
    bus_write(A_TM, tw(10, 20, 30));
    expect_reg("R6 busy after write", A_ST, BUSY_T);
    tick_once();
    expect_reg("R6 busy after tick 1", A_ST, BUSY_T);
    expect_reg("R8 old time runs tick 1", A_TM, tw(0, 0, 2));
    tick_once();
    expect_reg("R6 busy after tick 2", A_ST, BUSY_T);
    expect_reg("R8 old time runs tick 2", A_TM, tw(0, 0, 3));
    tick_once();
    expect_reg("R6 busy clear at tick 3", A_ST, 32'h0);
    expect_reg("R10 time committed exact", A_TM, tw(10, 20, 30));
  endtask

  task automatic t_date_commit();
    bus_write(A_DT, dw(1, 30, 2, 28));
    expect_reg("R7 date busy after write", A_ST, BUSY_D);
    tick_once();
    expect_reg("R8 old date during pend", A_DT, 32'h00000101);
    tick_once();
    expect_reg("R7 date busy after tick 2", A_ST, BUSY_D);
    tick_once();
    expect_reg("R7 date busy clear", A_ST, 32'h0);
    expect_reg("R7 date committed", A_DT, dw(1, 30, 2, 28));
  endtask

  task automatic roll_day(string tag, logic [31:0] start, logic [31:0] exp);
    set_date(start);
    set_time(tw(23, 59, 59));
    tick_once();
    expect_reg(tag, A_DT, exp);
  endtask

  task automatic t_calendar();
    roll_day("R4 leap Feb 28->29", dw(1, 30, 2, 28), dw(1, 30, 2, 29));
    expect_reg("R3 midnight wrap", A_TM, 32'h0);
    roll_day("R4 leap Feb 29->Mar 1", dw(1, 30, 2, 29), dw(1, 30, 3, 1));
    roll_day("R4 plain Feb 28->Mar 1", dw(0, 1, 2, 28), dw(0, 1, 3, 1));
    roll_day("R4 Apr 30->May 1", dw(0, 1, 4, 30), dw(0, 1, 5, 1));
    roll_day("R4 Jan 30->31", dw(0, 1, 1, 30), dw(0, 1, 1, 31));
    roll_day("R5 year 63 wraps to 0", dw(0, 63, 12, 31), dw(0, 0, 1, 1));
    roll_day("R5 leap bit set on year 30", dw(0, 29, 12, 31), dw(1, 30, 1, 1));
  endtask

  task automatic t_time_carries();
    logic [31:0] d0;
    bus_read(A_DT, d0);
    set_time(tw(0, 0, 59));
    tick_once();
    expect_reg("R3 seconds carry", A_TM, tw(0, 1, 0));
    set_time(tw(0, 59, 59));
    tick_once();
    expect_reg("R3 minutes carry", A_TM, tw(1, 0, 0));
    expect_reg("R3 hour carry leaves date", A_DT, d0);
  endtask

  task automatic t_rewrite();
    bus_write(A_TM, tw(1, 2, 3));
    tick_once();
    bus_write(A_TM, tw(4, 5, 6));
    tick_once();
    tick_once();
    expect_reg("R9 restart keeps busy", A_ST, BUSY_T);
    tick_once();
    expect_reg("R9 busy clears after restart", A_ST, 32'h0);
    expect_reg("R9 second value wins", A_TM, tw(4, 5, 6));
  endtask

  task automatic t_fields();
    set_time(32'hFFFF_FFFF);
    expect_reg("R11 time field mask", A_TM, 32'h001F3F3F);
    set_date(32'hFFFF_FFFF);
    expect_reg("R11 date field mask", A_DT, 32'h007F0F1F);
    expect_reg("R11 unmapped read", A_NONE, 32'h0);
    expect_reg("R11 gap read", 8'h04, 32'h0);
  endtask

  task automatic t_ignored();
    logic [31:0] d0, t0;
    set_time(tw(1, 2, 3));
    bus_read(A_DT, d0);
    bus_read(A_TM, t0);
    bus_write(A_NONE, 32'hFFFF_FFFF);
    bus_write(A_ST, 32'hFFFF_FFFF);
    expect_reg("R12 status unchanged", A_ST, 32'h0);
    expect_reg("R12 time unchanged", A_TM, t0);
    expect_reg("R12 date unchanged", A_DT, d0);
    check("R12 time value", t0, tw(1, 2, 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hold_and_step();
    t_time_commit();
    t_date_commit();
    t_calendar();
    t_time_carries();
    t_rewrite();
    t_fields();
    t_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule